// File: doc/BRIEF.md
# Multi-Mode 8x8 Hardware Multiplier

This block multiplies two 8-bit operands into a 16-bit product. A mode code selects whether each operand is read as unsigned or as two's-complement signed, and whether the result is an integer product or a fractional one. A fractional result is the integer product moved one place to the left, so two 1.7 operands give a 1.15 result. Alongside the product the block produces a carry flag and a zero flag for a status register.

An operation starts with a one-cycle start strobe that carries the mode and the operands. Exactly two clock edges later the product and flags are valid, and a one-cycle done pulse marks them. There is no back-pressure. The only flow rule is that a start in the cycle straight after an accepted start is dropped. A start in the done cycle is accepted, so a new operation can begin every two cycles. Product and flags hold until the next operation completes.

Top module: `mul8_multimode`

## Requirements
- R1: Mode code 0 multiplies both operands as unsigned integers; product = opa*opb.
- R2: Mode code 1 multiplies both operands as signed two's-complement integers; product is the low 16 bits of the signed product.
- R3: Mode code 2 multiplies a signed opa by an unsigned opb; product is the low 16 bits of that product.
- R4: Mode codes 4, 5 and 6 apply the operand readings of codes 0, 1 and 2. The product is the 16-bit integer product shifted left by one: bit 0 is zero and the top bit of the integer product is lost.
- R5: In mode code 5, 0x80 times 0x80 gives product 0x8000.
- R6: The carry flag equals bit 15 of the integer product before any fractional shift.
- R7: The zero flag is 1 exactly when the 16-bit output product is zero.
- R8: A start accepted at clock edge k sets done high for exactly the one cycle after edge k+1. Product and flags are valid in that cycle.
- R9: A start sampled at edge k+1, after an accepted start at edge k, is ignored. It produces no done pulse and does not change the product. A start at edge k+2 is accepted.
- R10: Product, carry and zero hold their values in every cycle in which done is low.
- R11: Mode codes 3 and 7 behave exactly as codes 0 and 4.
- R12: While rst_n is low, product, carry, zero and done are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start strobe; mode and operands are sampled with it |
| mode | input | 3 | Bit 2 fractional; codes 0/1/2 unsigned, signed, signed-by-unsigned |
| opa | input | 8 | First operand |
| opb | input | 8 | Second operand |
| product | output | 16 | Result, held until next completion |
| done | output | 1 | One-cycle pulse when product is new |
| carry | output | 1 | Bit 15 of the unshifted product |
| zero | output | 1 | Product is all zeros |

## Verification
The bench sweeps every first operand against a spread of second operands that includes 0x00, 0x01, 0x7F, 0x80 and 0xFF, in all eight mode codes. This catches a design that sign-extends the wrong operand in the mixed mode, which would give wrong high bytes whenever opb is above 0x7F. It also catches a carry taken after the shift, which shows up as a wrong flag on fractional results. The -1 by -1 fractional case is checked on its own, because a saturating design or one that keeps 17 bits would not give 0x8000. Every operation is issued in the done cycle of the one before it, and a separate start is raised while the block is busy. Together these expose a block that stalls, accepts the start it should drop, or lets the product drift between completions.

// File: rtl/mul8_pkg.sv
package mul8_pkg;

  // Decoded view of the 3-bit mode code
  typedef struct packed {
    logic a_sgn;  // first operand read as two's complement
    logic b_sgn;  // second operand read as two's complement
    logic frac;   // left-align the product by one bit
  } mode_dec_t;

  // Codes 3 and 7 fall back to unsigned (R11)
  function automatic mode_dec_t decode_mode(input logic [2:0] code);
    mode_dec_t d;
    d.a_sgn = code[0] ^ code[1];
    d.b_sgn = code[0] & ~code[1];
    d.frac  = code[2];
    return d;
  endfunction

endpackage

// File: rtl/mul8_opnd_ext.sv
module mul8_opnd_ext #(
  parameter int W = 8
) (
  input  logic [W-1:0]   val,
  input  logic           sgn,
  output logic signed [W:0] ext
);
  // One extra bit makes every reading a signed value of width W+1
  assign ext = $signed({sgn & val[W-1], val});
endmodule

// File: rtl/mul8_core.sv
module mul8_core #(
  parameter int W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_vld,
  input  logic signed [W:0] ea,
  input  logic signed [W:0] eb,
  input  logic              frac,
  output logic              done,
  output logic [2*W-1:0]    product,
  output logic              carry,
  output logic              zero
);
  localparam int PW = 2 * W;
  localparam int FW = 2 * W + 2;

  logic signed [FW-1:0] full;
  logic [PW-1:0]        raw;
  logic [PW-1:0]        res;

  assign full = ea * eb;
  assign raw  = full[PW-1:0];
  assign res  = frac ? {raw[PW-2:0], 1'b0} : raw;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done    <= 1'b0;
      product <= '0;
      carry   <= 1'b0;
      zero    <= 1'b0;
    end else begin
      done <= in_vld;
      if (in_vld) begin
        product <= res;
        carry   <= raw[PW-1];
        zero    <= (res == '0);
      end
    end
  end

  // R6: operands of W+1 bits never overflow the two top sign bits
  p_sign_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |-> (full[FW-1] == full[FW-2]));

  // R7: zero flag agrees with the registered product
  p_zero_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (zero == (product == '0)));

  // R10: outputs hold between completions
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(product) && $stable(carry) && $stable(zero)));

  // R4: fractional results always have bit 0 clear
  p_frac_lsb_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && frac) |=> !product[0]);

endmodule

// File: rtl/mul8_multimode.sv
module mul8_multimode #(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [2:0]     mode,
  input  logic [W-1:0]   opa,
  input  logic [W-1:0]   opb,
  output logic [2*W-1:0] product,
  output logic           done,
  output logic           carry,
  output logic           zero
);
  import mul8_pkg::*;

  mode_dec_t         dec;
  logic              accept;
  logic signed [W:0] ea_d, eb_d;
  logic signed [W:0] ea_q, eb_q;
  logic              frac_q;
  logic              s1_vld;

  assign dec    = decode_mode(mode);
  assign accept = start & ~s1_vld;

  mul8_opnd_ext #(.W(W)) i_ext_a (.val(opa), .sgn(dec.a_sgn), .ext(ea_d));
  mul8_opnd_ext #(.W(W)) i_ext_b (.val(opb), .sgn(dec.b_sgn), .ext(eb_d));

  // Stage 1: capture extended operands
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_vld <= 1'b0;
      ea_q   <= '0;
      eb_q   <= '0;
      frac_q <= 1'b0;
    end else begin
      s1_vld <= accept;
      if (accept) begin
        ea_q   <= ea_d;
        eb_q   <= eb_d;
        frac_q <= dec.frac;
      end
    end
  end

  // Stage 2: multiply, align, flags
  mul8_core #(.W(W)) i_core (
    .clk    (clk),
    .rst_n  (rst_n),
    .in_vld (s1_vld),
    .ea     (ea_q),
    .eb     (eb_q),
    .frac   (frac_q),
    .done   (done),
    .product(product),
    .carry  (carry),
    .zero   (zero)
  );

  // R8: accepted start yields done two edges later
  p_done_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !s1_vld) |=> ##1 done);

  // R8: done is a single-cycle pulse
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9: a start while busy does not open a new operation
  p_busy_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
    s1_vld |=> !s1_vld);

endmodule

// File: tb/test_mul8_multimode.sv
`timescale 1ns/1ps
module test_mul8_multimode;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  mode = 3'd0;
  logic [7:0]  opa = 8'd0, opb = 8'd0;
  logic [15:0] product;
  logic        done, carry, zero;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  mul8_multimode i_mul8_multimode (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
    .opa(opa), .opb(opb), .product(product), .done(done),
    .carry(carry), .zero(zero)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Integer product per requirement R1/R2/R3/R11; fraction R4
  function automatic logic [15:0] raw_prod(input logic [2:0] m,
                                           input logic [7:0] a, input logic [7:0] b);
    int av, bv;
    logic [1:0] k;
    k  = m[1:0];
    av = (k == 2'd1 || k == 2'd2) ? int'($signed(a)) : int'(a);
    bv = (k == 2'd1) ? int'($signed(b)) : int'(b);
    return 16'(av * bv);
  endfunction

  function automatic string req_of(input logic [2:0] m);
    case (m)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3, 3'd7: return "R11";
      default: return "R4";
    endcase
  endfunction

  // Called at a negedge; returns at the negedge of the done cycle
  task automatic do_op(input logic [2:0] m, input logic [7:0] a, input logic [7:0] b);
    logic [15:0] raw, exp;
    raw = raw_prod(m, a, b);
    exp = m[2] ? {raw[14:0], 1'b0} : raw;
    start = 1'b1; mode = m; opa = a; opb = b;
    @(negedge clk);
    start = 1'b0;
    check(done == 1'b0, "R8", "done early", done, 0);
    @(negedge clk);
    check(done == 1'b1, "R8", "done missing", done, 1);
    check(product == exp, req_of(m), $sformatf("product m=%0d a=%02h b=%02h", m, a, b),
          product, exp);
    check(carry == raw[15], "R6", "carry", carry, raw[15]);
    check(zero == (exp == 16'd0), "R7", "zero", zero, exp == 16'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12: reset state
    check(product == 16'd0 && !done && !carry && !zero, "R12", "reset outputs",
          {product, done, carry, zero}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R5: -1.0 times -1.0 fractional signed wraps
    do_op(3'd5, 8'h80, 8'h80);
    check(product == 16'h8000, "R5", "frac wrap", product, 16'h8000);

    // R9/R10: start while busy is ignored, outputs hold
    start = 1'b1; mode = 3'd0; opa = 8'd3; opb = 8'd5;
    @(negedge clk);
    opa = 8'd7; opb = 8'd9;  // start still high: must be dropped
    @(negedge clk);
    start = 1'b0;
    check(done && product == 16'd15, "R9", "first op result", product, 15);
    @(negedge clk);
    check(!done, "R9", "busy start made done", done, 0);
    check(product == 16'd15, "R10", "product held", product, 15);
    @(negedge clk);

    // Sweeps: all modes, all opa, spread of opb
    for (int m = 0; m < 8; m++) begin
      for (int a = 0; a < 256; a++) begin
        for (int bi = 0; bi < 20; bi++) begin
          logic [7:0] b;
          case (bi)
            15: b = 8'h00;
            16: b = 8'h01;
            17: b = 8'h7f;
            18: b = 8'h80;
            19: b = 8'hff;
            default: b = 8'(bi * 17 + 3);
          endcase
          do_op(3'(m), 8'(a), b);
        end
      end
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule